// File: doc/BRIEF.md
# Dual Down-Counting Timer

This block holds two independent 32-bit counters that count down. Software reaches them through a simple synchronous 32-bit register port. Each counter can be fed in one of two ways. The first is the system clock, divided by a power of two that software picks. The second is a fixed reference tick input. Each timer can run in one of two modes. In one-shot mode it expires once and then switches itself off. In periodic mode it refills from its own reload register every time it expires.

Both timers share one packed control word and one packed status word. When a timer expires, it raises its status flag and its interrupt line, and both stay high until software clears them. A status flag is cleared by writing a word that has a zero in that flag's bit position. Ones in the written word leave the flags unchanged, so one timer can be acknowledged without a read-modify-write that could lose the other timer's event.

Top module: `dual_tmr`

## Requirements
- R1: After reset, every register reads zero, both timers are stopped and both interrupt lines are low.
- R2: The control word has the following fields. Bit 2i enables timer i. Bit 2i+1 selects periodic mode for timer i. Bit 11+i makes timer i count on the reference tick. Bits 19+3i to 21+3i hold the divider exponent for timer i. Only these bits are stored, and every other bit reads back as zero.
- R3: An enabled timer using the system-clock source with divider exponent d takes one tick every 2^d enabled cycles. The first tick comes 2^d cycles after the enable takes effect. Each tick at a nonzero value lowers the value by one.
- R4: In one-shot mode (bit 2i+1 = 0), a tick while the value is zero raises the timer's flag. The value stays at zero and the timer's enable bit is cleared by hardware.
- R5: In periodic mode, a tick while the value is zero raises the flag and loads the reload register. The enable bit stays set.
- R6: Status bit 0 is the flag for timer 0 and status bit 8 is the flag for timer 1. Writing 0 to a flag's bit clears that flag, and writing 1 leaves it unchanged. If an expiry and a clearing write fall in the same cycle, the flag ends up set.
- R7: Output irq[i] is high exactly when timer i's flag is set, and it stays high until software clears the flag.
- R8: With the reference-source bit set, the timer takes one tick for each cycle in which ref_tick is high, and the divider has no effect.
- R9: Each timer's divider count restarts from zero whenever the timer is disabled.
- R10: A write to a value register takes effect at the next clock edge and wins over a tick in that same cycle.
- R11: The byte address map is: control 0x00, status 0x04, timer 0 reload 0x10 and value 0x14, timer 1 reload 0x18 and value 0x1C. The two timers run independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | Write when high, read when low |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| ref_tick | input | 1 | Fixed reference tick, one cycle per tick |
| irq | output | 2 | Per-timer interrupt, equal to its status flag |

## Verification
Read data follows the address in the same cycle, while any write shows up only after the next rising edge. The bench therefore samples on falling edges, after a known count of rising edges. Once an enable takes effect, a timer with divider exponent d and start value N reaches value N-k after k·2^d edges. Its flag appears after (N+1)·2^d edges, and in periodic mode the reload period is R+1 ticks. The bench computes expected values from this model, one edge count per vector. Same-cycle collisions, such as a clearing write on the expiry edge or a value write on a tick edge, are set up by starting the write at the falling edge just before the target rising edge.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int NTMR    = 2;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int DIV_W   = 3;

    // Control word layout (fields decoded by each timer slice)
    localparam int SRC_BIT0    = 11;
    localparam int DIV_LSB0    = 19;
    localparam int STAT_STRIDE = 8;

    // Register byte offsets
    localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] A_STAT = 5'h04;
    localparam logic [ADDR_W-1:0] A_RLD0 = 5'h10;
    localparam logic [ADDR_W-1:0] A_VAL0 = 5'h14;
    localparam int                A_STEP = 8;

    function automatic logic [DATA_W-1:0] ctrl_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NTMR; i++) begin
            m[2*i]            = 1'b1;
            m[2*i+1]          = 1'b1;
            m[SRC_BIT0+i]     = 1'b1;
            for (int b = 0; b < DIV_W; b++)
                m[DIV_LSB0 + DIV_W*i + b] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/dtmr_presc.sv
module dtmr_presc #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam int PC_W = (1 << DIV_W) - 1;

    typedef struct packed {
        logic [PC_W-1:0] cnt;
    } psc_st_t;

    psc_st_t st_d, st_q;
    logic [PC_W-1:0] lim;

    always_comb begin
        lim    = ~({PC_W{1'b1}} << div_i);
        tick_o = en_i && (st_q.cnt == lim);
        st_d   = st_q;
        if (!en_i || tick_o)
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: a disabled timer leaves its divider count at zero
    a_r9_presc_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> st_q.cnt == '0);

endmodule

// File: rtl/dtmr_chan.sv
module dtmr_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             rld_en_i,
    input  logic [CNT_W-1:0] rld_val_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] val_o,
    output logic             expire_o
);
    typedef struct packed {
        logic [CNT_W-1:0] val;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     hit;
    logic     at_zero;

    always_comb begin
        hit      = en_i && tick_i && !wr_i;
        at_zero  = (st_q.val == '0);
        expire_o = hit && at_zero;
        st_d     = st_q;
        if (wr_i)
            st_d.val = wdata_i;
        else if (hit) begin
            if (!at_zero)
                st_d.val = st_q.val - CNT_W'(1);
            else if (rld_en_i)
                st_d.val = rld_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val_o = st_q.val;

    // R3: a tick at a nonzero value steps down by one
    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && tick_i && !wr_i && st_q.val != '0 |=> st_q.val == $past(st_q.val) - CNT_W'(1));

    // R10: software write wins over a tick in the same cycle
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> st_q.val == $past(wdata_i));

endmodule

// File: rtl/dual_tmr.sv
module dual_tmr
    import dtmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ref_tick,
    output logic [NTMR-1:0]   irq
);
    localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask();

    typedef struct packed {
        logic [DATA_W-1:0]           ctrl;
        logic [NTMR-1:0]             flag;
        logic [NTMR-1:0][CNT_W-1:0]  rld;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                        wr_ctrl;
    logic                        wr_stat;
    logic [NTMR-1:0]             wr_rld;
    logic [NTMR-1:0]             wr_val;
    logic [NTMR-1:0]             tick;
    logic [NTMR-1:0]             expire;
    logic [NTMR-1:0][CNT_W-1:0]  val;

    assign wr_ctrl = reg_sel && reg_wr && (reg_addr == A_CTRL);
    assign wr_stat = reg_sel && reg_wr && (reg_addr == A_STAT);

    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
        localparam int EN_B  = 2*i;
        localparam int RL_B  = 2*i + 1;
        localparam int SRC_B = SRC_BIT0 + i;
        localparam int DIV_L = DIV_LSB0 + DIV_W*i;
        localparam logic [ADDR_W-1:0] A_RLD = A_RLD0 + ADDR_W'(A_STEP*i);
        localparam logic [ADDR_W-1:0] A_VAL = A_VAL0 + ADDR_W'(A_STEP*i);

        logic psc_tick;

        assign wr_rld[i] = reg_sel && reg_wr && (reg_addr == A_RLD);
        assign wr_val[i] = reg_sel && reg_wr && (reg_addr == A_VAL);

        dtmr_presc #(.DIV_W(DIV_W)) u_psc (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (st_q.ctrl[EN_B]),
            .div_i  (st_q.ctrl[DIV_L +: DIV_W]),
            .tick_o (psc_tick)
        );

        assign tick[i] = st_q.ctrl[SRC_B] ? ref_tick : psc_tick;

        dtmr_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (st_q.ctrl[EN_B]),
            .tick_i    (tick[i]),
            .rld_en_i  (st_q.ctrl[RL_B]),
            .rld_val_i (st_q.rld[i]),
            .wr_i      (wr_val[i]),
            .wdata_i   (reg_wdata[CNT_W-1:0]),
            .val_o     (val[i]),
            .expire_o  (expire[i])
        );

        assign irq[i] = st_q.flag[i];

        // R6: expiry always leaves the flag set
        a_r6_flag_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
            expire[i] |=> st_q.flag[i]);

        // R4: one-shot expiry switches the timer off
        a_r4_oneshot_halts: assert property (@(posedge clk) disable iff (!rst_n)
            expire[i] && !st_q.ctrl[RL_B] && !wr_ctrl |=> !st_q.ctrl[EN_B]);

        // R5: periodic expiry refills from the reload register
        a_r5_reload_taken: assert property (@(posedge clk) disable iff (!rst_n)
            expire[i] && st_q.ctrl[RL_B] && !wr_val[i] |=> val[i] == $past(st_q.rld[i]));

        // R7: the interrupt holds until a status write
        a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] && !wr_stat |=> irq[i]);
    end

    always_comb begin
        st_d = st_q;
        if (wr_ctrl)
            st_d.ctrl = reg_wdata & CTRL_MASK;
        else begin
            for (int i = 0; i < NTMR; i++)
                if (expire[i] && !st_q.ctrl[2*i+1])
                    st_d.ctrl[2*i] = 1'b0;
        end
        for (int i = 0; i < NTMR; i++) begin
            st_d.flag[i] = (st_q.flag[i] && !(wr_stat && !reg_wdata[STAT_STRIDE*i]))
                           || expire[i];
            if (wr_rld[i])
                st_d.rld[i] = reg_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL)
            reg_rdata = st_q.ctrl;
        else if (reg_addr == A_STAT) begin
            for (int i = 0; i < NTMR; i++)
                reg_rdata[STAT_STRIDE*i] = st_q.flag[i];
        end else begin
            for (int i = 0; i < NTMR; i++) begin
                if (reg_addr == A_RLD0 + ADDR_W'(A_STEP*i))
                    reg_rdata = DATA_W'(st_q.rld[i]);
                if (reg_addr == A_VAL0 + ADDR_W'(A_STEP*i))
                    reg_rdata = DATA_W'(val[i]);
            end
        end
    end

endmodule

// File: tb/sim_dual_tmr.sv
module sim_dual_tmr;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    typedef struct packed {
        logic        tmr;
        logic [2:0]  div;
        logic        rld;
        logic [31:0] init;
        logic [31:0] rel;
        logic [15:0] wt;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 3'd0, 1'b0, 32'd10, 32'd0, 16'd5},
        '{1'b0, 3'd0, 1'b0, 32'd3,  32'd0, 16'd10},
        '{1'b0, 3'd2, 1'b0, 32'd20, 32'd0, 16'd17},
        '{1'b0, 3'd0, 1'b1, 32'd2,  32'd4, 16'd8},
        '{1'b1, 3'd1, 1'b0, 32'd7,  32'd0, 16'd9},
        '{1'b1, 3'd3, 1'b1, 32'd1,  32'd2, 16'd40},
        '{1'b1, 3'd0, 1'b0, 32'd0,  32'd0, 16'd1},
        '{1'b0, 3'd7, 1'b0, 32'd5,  32'd0, 16'd300}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ref_tick = 1'b0;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;

    dual_tmr u0 (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ref_tick(ref_tick), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    // combinational read; caller positions time away from the edge
    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] vaddr(input logic t);
        return t ? 32'h1C : 32'h14;
    endfunction

    function automatic void model(input logic [2:0] d, input logic r,
                                  input int unsigned n, input int unsigned rel,
                                  input int unsigned wt, output int unsigned v,
                                  output bit fl, output bit en);
        int unsigned ticks;
        ticks = wt >> d;
        if (ticks <= n) begin
            v = n - ticks; fl = 0; en = 1;
        end else begin
            fl = 1;
            if (!r) begin v = 0; en = 0; end
            else begin v = rel - ((ticks - n - 1) % (rel + 1)); en = 1; end
        end
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        rd(5'h00, r); chk("R1 ctrl", r, 0);
        rd(5'h04, r); chk("R1 status", r, 0);
        rd(5'h10, r); chk("R1 reload0", r, 0);
        rd(5'h14, r); chk("R1 value0", r, 0);
        @(negedge clk);
        rd(5'h18, r); chk("R1 reload1", r, 0);
        rd(5'h1C, r); chk("R1 value1", r, 0);
        chk("R1 irq", {30'd0, irq}, 0);
        rst_n = 1'b1;

        // R2: only defined control bits are stored
        wr(5'h00, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(5'h00, r); chk("R2 ctrl mask", r, 32'h01F8_180F);
        wr(5'h00, 32'h0);

        // R11: reload registers at their own addresses
        wr(5'h10, 32'h1234_5678);
        wr(5'h18, 32'h9ABC_DEF0);
        @(negedge clk);
        rd(5'h10, r); chk("R11 reload0 addr", r, 32'h1234_5678);
        rd(5'h18, r); chk("R11 reload1 addr", r, 32'h9ABC_DEF0);

        // table walk: R3 R4 R5 R6 R7 R11
        for (int k = 0; k < NVEC; k++) begin
            vec_t v;
            logic [31:0] cw;
            int unsigned ev;
            bit ef, een;
            v = VECS[k];
            cw = (32'd1 << (2*v.tmr)) | (32'(v.rld) << (2*v.tmr + 1))
               | (32'(v.div) << (19 + 3*v.tmr));
            model(v.div, v.rld, v.init, v.rel, 32'(v.wt), ev, ef, een);
            wr(5'h00, 32'h0);
            wr(5'h04, 32'h0);
            wr(v.tmr ? 5'h18 : 5'h10, v.rel);
            wr(5'(vaddr(v.tmr)), v.init);
            wr(5'h00, cw);
            repeat (int'(v.wt)) @(posedge clk);
            @(negedge clk);
            rd(5'(vaddr(v.tmr)), r);
            chk(ef ? (v.rld ? "R5 value" : "R4 value") : "R3 value", r, ev);
            rd(5'h04, r);
            chk("R6 status", r, ef ? (32'd1 << (8*v.tmr)) : 32'd0);
            rd(5'h00, r);
            chk(v.rld ? "R5 ctrl" : "R4 ctrl", r, een ? cw : (cw & ~(32'd1 << (2*v.tmr))));
            chk("R7 irq", {30'd0, irq}, ef ? (32'd1 << v.tmr) : 32'd0);
        end

        // R6: per-flag clear by zero bit
        wr(5'h00, 32'h0); wr(5'h04, 32'h0);
        wr(5'h14, 32'h0); wr(5'h1C, 32'h0);
        wr(5'h00, 32'h5);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd(5'h04, r); chk("R6 both flags", r, 32'h101);
        chk("R7 both irq", {30'd0, irq}, 32'h3);
        wr(5'h04, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(5'h04, r); chk("R6 ones keep", r, 32'h101);
        wr(5'h04, 32'hFFFF_FEFF);
        @(negedge clk);
        rd(5'h04, r); chk("R6 clear bit8 only", r, 32'h001);
        chk("R7 irq after clear", {30'd0, irq}, 32'h1);
        wr(5'h04, 32'hFFFF_FFFE);
        @(negedge clk);
        rd(5'h04, r); chk("R6 clear bit0", r, 32'h0);

        // R6: set wins over clear in the expiry cycle
        wr(5'h00, 32'h0);
        wr(5'h14, 32'd2);
        wr(5'h00, 32'h1);
        repeat (2) @(posedge clk);
        wr(5'h04, 32'h0);
        @(negedge clk);
        rd(5'h04, r); chk("R6 set beats clear", r, 32'h1);

        // R8: reference tick source
        wr(5'h00, 32'h0); wr(5'h04, 32'h0);
        wr(5'h1C, 32'd5);
        wr(5'h00, 32'h0000_1004);
        for (int p = 0; p < 3; p++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
            @(negedge clk);
        end
        rd(5'h1C, r); chk("R8 ref ticks", r, 32'd3 - 32'd1);

        // R9: divider restarts after a disable
        wr(5'h00, 32'h0);
        wr(5'h14, 32'd10);
        wr(5'h00, 32'h0010_0001);
        repeat (2) @(posedge clk);
        wr(5'h00, 32'h0);
        wr(5'h00, 32'h0010_0001);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(5'h14, r); chk("R9 no early tick", r, 32'd10);
        @(posedge clk);
        @(negedge clk);
        rd(5'h14, r); chk("R9 tick after full period", r, 32'd9);

        // R10: value write beats a same-cycle tick
        wr(5'h00, 32'h0);
        wr(5'h14, 32'd5);
        wr(5'h00, 32'h1);
        wr(5'h14, 32'd100);
        @(negedge clk);
        rd(5'h14, r); chk("R10 write wins", r, 32'd100);
        @(posedge clk);
        @(negedge clk);
        rd(5'h14, r); chk("R10 counts on", r, 32'd99);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule